// File: doc/BRIEF.md
# Switching Time Extractor

The block measures the four switching intervals of a power transistor from a double-pulse event. It receives a synchronous stream of gate-emitter voltage and collector current samples, each marked by a sample strobe. It also receives two reference levels: the full gate swing and the peak collector current. An arm command latches both references, the analysis mode and a window limit. The block derives a low (about 10 %) threshold and a high (about 90 %) threshold from each reference once, using shift-and-add arithmetic. It then follows a fixed chain of three crossings, one on the gate signal and two on the current.

In turn-on mode the chain yields the turn-on delay and the rise time. In turn-off mode it yields the turn-off delay and the fall time. Every interval is a count of accepted samples. The derived total time is the sum of the two intervals. A completed chain raises a one-cycle valid pulse and leaves the results on the outputs until the next arm. A crossing that does not arrive within the window limit ends the measurement with a timeout flag and no valid pulse.

Top module: `swx_extract`

## Requirements
- R1: On the arm cycle the block latches the mode, the limit and the low and high thresholds of both references, where low = (r>>4)+(r>>5)+(r>>8)+(r>>9) with integer shifts and high = r − low. The reference inputs have no effect after that cycle.
- R2: With mode_off=0 (turn-on), the gate event is the first sample with vge ≥ gate low. The first current event is the next later sample with ic ≥ current low. The second current event is the next later sample with ic ≥ current high. td_on is the sample-index distance from the gate event to the first current event, and t_rise is the distance from the first current event to the second.
- R3: With mode_off=1 (turn-off), the gate event is the first sample with vge ≤ gate high. The first current event is the next later sample with ic ≤ current high. The second current event is the next later sample with ic ≤ current low. td_off and t_fall are measured in the same way as in R2.
- R4: t_on = td_on + t_rise and t_off = td_off + t_fall. The pair belonging to the other mode reads zero.
- R5: Each event is looked for only on samples after the preceding event. A sample that satisfies a later condition earlier in the chain is ignored, so every interval is at least 1.
- R6: Cycles with smp_valid low are not samples. They are neither counted nor compared.
- R7: Sample indices count from 1 at the first sample after the arm cycle. If the distance from arm to the gate event, or between two consecutive events, would exceed limit, timed_out rises on the sample at which the distance equals limit without a crossing. No valid pulse follows, and all counts read zero. A distance equal to limit is accepted.
- R8: res_valid is high for exactly the one cycle after the final event sample. The results then hold until the next arm. Arm clears all counts and timed_out.
- R9: After reset every count is zero and res_valid and timed_out are low.
- R10: An arm during a measurement abandons it and starts a new one. No result of the abandoned measurement appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a measurement; latches references, mode, limit |
| mode_off | input | 1 | 0 = turn-on analysis, 1 = turn-off analysis |
| vge_full | input | DW | Full gate swing reference |
| ic_peak | input | DW | Peak collector current reference |
| limit | input | CW | Maximum sample distance per crossing |
| smp_valid | input | 1 | Sample strobe |
| vge_smp | input | DW | Gate-emitter voltage sample |
| ic_smp | input | DW | Collector current sample |
| td_on | output | CW | Turn-on delay in samples |
| t_rise | output | CW | Rise time in samples |
| td_off | output | CW | Turn-off delay in samples |
| t_fall | output | CW | Fall time in samples |
| t_on | output | CW+1 | Total turn-on time |
| t_off | output | CW+1 | Total turn-off time |
| res_valid | output | 1 | One-cycle result pulse |
| timed_out | output | 1 | Measurement aborted by the window limit |

## Verification
The bench builds the block with DW=12 and CW=10, keeping the fine threshold variant and inclusive comparison. A 12-bit range lets full-scale references of 4000 and 4095 exercise the truncation of every shift term. The thresholds landing exactly on sample values test the inclusive edge. Windows of 20 samples make the accepted distance equal to the limit and the rejected distance of limit+1 cheap to reach in both modes and at each of the three stages.

// File: rtl/swx_pkg.sv
package swx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_GATE   = 2'd1,
      ST_FIRST  = 2'd2,
      ST_SECOND = 2'd3
   } swx_state_e;
endpackage

// File: rtl/swx_thresh.sv
module swx_thresh #(
   parameter int DW   = 12,
   parameter bit FINE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] ref_val,
   output logic [DW-1:0] thr_lo,
   output logic [DW-1:0] thr_hi
);
   logic [DW-1:0] lo_calc;

   generate
      if (FINE) begin : g_fine
         assign lo_calc = (ref_val >> 4) + (ref_val >> 5) + (ref_val >> 8) + (ref_val >> 9);
      end else begin : g_coarse
         assign lo_calc = (ref_val >> 4) + (ref_val >> 5);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_lo <= '0;
         thr_hi <= '0;
      end else if (load) begin
         thr_lo <= lo_calc;
         thr_hi <= ref_val - lo_calc;
      end
   end
endmodule

// File: rtl/swx_cross.sv
module swx_cross #(
   parameter int DW   = 12,
   parameter bit INCL = 1'b1
) (
   input  logic [DW-1:0] smp,
   input  logic [DW-1:0] thr,
   input  logic          dir_rise,
   output logic          hit
);
   generate
      if (INCL) begin : g_incl
         assign hit = dir_rise ? (smp >= thr) : (smp <= thr);
      end else begin : g_excl
         assign hit = dir_rise ? (smp > thr) : (smp < thr);
      end
   endgenerate
endmodule

// File: rtl/swx_seq.sv
module swx_seq
   import swx_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          mode_in,
   input  logic [CW-1:0] limit,
   input  logic          smp_valid,
   input  logic          hit_gate,
   input  logic          hit_first,
   input  logic          hit_second,
   output logic          mode_q,
   output logic          done,
   output logic          to_flag,
   output logic [CW-1:0] r_delay,
   output logic [CW-1:0] r_edge,
   output logic [CW:0]   r_total
);
   swx_state_e    state;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_q;
   logic [CW-1:0] delay_tmp;
   logic [CW:0]   step;
   logic          hit_cur;

   assign step = {1'b0, cnt} + 1'b1;

   always_comb begin
      case (state)
         ST_GATE:   hit_cur = hit_gate;
         ST_FIRST:  hit_cur = hit_first;
         ST_SECOND: hit_cur = hit_second;
         default:   hit_cur = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= 1'b0;
         done      <= 1'b0;
         to_flag   <= 1'b0;
         cnt       <= '0;
         lim_q     <= '0;
         delay_tmp <= '0;
         r_delay   <= '0;
         r_edge    <= '0;
         r_total   <= '0;
      end else begin
         done <= 1'b0;
         if (arm) begin
            state     <= ST_GATE;
            mode_q    <= mode_in;
            lim_q     <= limit;
            cnt       <= '0;
            to_flag   <= 1'b0;
            delay_tmp <= '0;
            r_delay   <= '0;
            r_edge    <= '0;
            r_total   <= '0;
         end else if (smp_valid && state != ST_IDLE) begin
            if (hit_cur) begin
               cnt <= '0;
               case (state)
                  ST_GATE:  state <= ST_FIRST;
                  ST_FIRST: begin
                     delay_tmp <= step[CW-1:0];
                     state     <= ST_SECOND;
                  end
                  default: begin
                     r_delay <= delay_tmp;
                     r_edge  <= step[CW-1:0];
                     r_total <= {1'b0, delay_tmp} + step;
                     done    <= 1'b1;
                     state   <= ST_IDLE;
                  end
               endcase
            end else if (step >= {1'b0, lim_q}) begin
               to_flag <= 1'b1;
               state   <= ST_IDLE;
               cnt     <= '0;
            end else begin
               cnt <= step[CW-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/swx_extract.sv
module swx_extract #(
   parameter int DW   = 12,
   parameter int CW   = 16,
   parameter bit FINE = 1'b1,
   parameter bit INCL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          mode_off,
   input  logic [DW-1:0] vge_full,
   input  logic [DW-1:0] ic_peak,
   input  logic [CW-1:0] limit,
   input  logic          smp_valid,
   input  logic [DW-1:0] vge_smp,
   input  logic [DW-1:0] ic_smp,
   output logic [CW-1:0] td_on,
   output logic [CW-1:0] t_rise,
   output logic [CW-1:0] td_off,
   output logic [CW-1:0] t_fall,
   output logic [CW:0]   t_on,
   output logic [CW:0]   t_off,
   output logic          res_valid,
   output logic          timed_out
);
   localparam int MinDw = FINE ? 10 : 6;

   generate
      if (DW < MinDw) begin : g_bad_dw
         $error("swx_extract: DW too small for threshold shifts");
      end
      if (CW < 2) begin : g_bad_cw
         $error("swx_extract: CW must be at least 2");
      end
   endgenerate

   logic [DW-1:0] v_lo, v_hi, i_lo, i_hi;
   logic [DW-1:0] thr_gate, thr_first, thr_second;
   logic          hit_gate, hit_first, hit_second;
   logic          mode_q;
   logic [CW-1:0] r_delay, r_edge;
   logic [CW:0]   r_total;

   swx_thresh #(.DW(DW), .FINE(FINE)) u_thr_v (
      .clk(clk), .rst_n(rst_n), .load(arm), .ref_val(vge_full),
      .thr_lo(v_lo), .thr_hi(v_hi));

   swx_thresh #(.DW(DW), .FINE(FINE)) u_thr_i (
      .clk(clk), .rst_n(rst_n), .load(arm), .ref_val(ic_peak),
      .thr_lo(i_lo), .thr_hi(i_hi));

   assign thr_gate   = mode_q ? v_hi : v_lo;
   assign thr_first  = mode_q ? i_hi : i_lo;
   assign thr_second = mode_q ? i_lo : i_hi;

   swx_cross #(.DW(DW), .INCL(INCL)) u_cr_gate (
      .smp(vge_smp), .thr(thr_gate), .dir_rise(!mode_q), .hit(hit_gate));
   swx_cross #(.DW(DW), .INCL(INCL)) u_cr_first (
      .smp(ic_smp), .thr(thr_first), .dir_rise(!mode_q), .hit(hit_first));
   swx_cross #(.DW(DW), .INCL(INCL)) u_cr_second (
      .smp(ic_smp), .thr(thr_second), .dir_rise(!mode_q), .hit(hit_second));

   swx_seq #(.CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode_in(mode_off), .limit(limit),
      .smp_valid(smp_valid), .hit_gate(hit_gate), .hit_first(hit_first),
      .hit_second(hit_second), .mode_q(mode_q), .done(res_valid),
      .to_flag(timed_out), .r_delay(r_delay), .r_edge(r_edge), .r_total(r_total));

   assign td_on  = mode_q ? '0 : r_delay;
   assign t_rise = mode_q ? '0 : r_edge;
   assign t_on   = mode_q ? '0 : r_total;
   assign td_off = mode_q ? r_delay : '0;
   assign t_fall = mode_q ? r_edge  : '0;
   assign t_off  = mode_q ? r_total : '0;
endmodule

// File: rtl/swx_extract_chk.sv
module swx_extract_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic [CW-1:0] td_on,
   input logic [CW-1:0] t_rise,
   input logic [CW-1:0] td_off,
   input logic [CW-1:0] t_fall,
   input logic [CW:0]   t_on,
   input logic [CW:0]   t_off,
   input logic          res_valid,
   input logic          timed_out
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R8
   AST_NO_VALID_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out |-> !res_valid); // R7
   AST_TOTAL_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (t_on == {1'b0, td_on} + {1'b0, t_rise}) &&
                    (t_off == {1'b0, td_off} + {1'b0, t_fall})); // R4
   AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((td_off == '0) && (t_fall == '0)) || ((td_on == '0) && (t_rise == '0))); // R4
   AST_NONZERO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (t_rise != '0) || (t_fall != '0)); // R5
   AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> res_valid || ($stable(td_on) && $stable(t_rise) && $stable(td_off) &&
                             $stable(t_fall) && $stable(t_on) && $stable(t_off))); // R8
   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !timed_out && !res_valid && (t_on == '0) && (t_off == '0)); // R8
endmodule

bind swx_extract swx_extract_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .td_on(td_on), .t_rise(t_rise),
   .td_off(td_off), .t_fall(t_fall), .t_on(t_on), .t_off(t_off),
   .res_valid(res_valid), .timed_out(timed_out));

// File: tb/swx_extract_tb.sv
module swx_extract_tb;
   localparam int DW = 12;
   localparam int CW = 10;

   typedef struct {
      logic          to;
      logic [CW-1:0] a_on, b_rise, c_off, d_fall;
      logic [CW:0]   e_on, f_off;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic          mode_off = 1'b0;
   logic [DW-1:0] vge_full = '0, ic_peak = '0;
   logic [CW-1:0] limit = '0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] vge_smp = '0, ic_smp = '0;
   logic [CW-1:0] td_on, t_rise, td_off, t_fall;
   logic [CW:0]   t_on, t_off;
   logic          res_valid, timed_out;

   int   checks = 0;
   int   errors = 0;
   bit   done = 0;
   exp_t q[$];
   exp_t last;
   logic prev_to = 1'b0;

   always #4 clk = ~clk;

   swx_extract #(.DW(DW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode_off(mode_off),
      .vge_full(vge_full), .ic_peak(ic_peak), .limit(limit),
      .smp_valid(smp_valid), .vge_smp(vge_smp), .ic_smp(ic_smp),
      .td_on(td_on), .t_rise(t_rise), .td_off(td_off), .t_fall(t_fall),
      .t_on(t_on), .t_off(t_off), .res_valid(res_valid), .timed_out(timed_out));

   function automatic int lo_of(int r);
      return (r >> 4) + (r >> 5) + (r >> 8) + (r >> 9);
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp_all(exp_t e);
      chk({e.tag, " td_on"},   td_on,   e.a_on);
      chk({e.tag, " t_rise"},  t_rise,  e.b_rise);
      chk({e.tag, " td_off"},  td_off,  e.c_off);
      chk({e.tag, " t_fall"},  t_fall,  e.d_fall);
      chk({e.tag, " t_on"},    t_on,    e.e_on);
      chk({e.tag, " t_off"},   t_off,   e.f_off);
      chk({e.tag, " timeout"}, timed_out, e.to);
   endtask

   // monitor: pops an expected item on each valid pulse or timeout rise
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid || (timed_out && !prev_to)) begin
            if (q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R8 unexpected result act=1 exp=0");
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({e.tag, " valid-vs-timeout"}, res_valid, !e.to);
               cmp_all(e);
               last = e;
            end
         end
         prev_to = timed_out;
      end
   end

   task automatic do_arm(bit m, int vr, int ir, int lim);
      @(negedge clk);
      arm = 1'b1; mode_off = m;
      vge_full = DW'(vr); ic_peak = DW'(ir); limit = CW'(lim);
      smp_valid = 1'b0;
      @(negedge clk);
      arm = 1'b0;
      vge_full = DW'(1); ic_peak = DW'(1); limit = CW'(1); mode_off = !m; // R1: ignored after arm
   endtask

   // driver: one measurement; sample index k starts at 1 after the arm cycle
   task automatic meas(string tag, bit m, int vr, int ir, int lim,
                       int g0, int g1, int g2, bit gappy, bit spike, bit push);
      int   vlo, vhi, ilo, ihi, e1, e2, n;
      exp_t e;
      vlo = lo_of(vr); vhi = vr - vlo;
      ilo = lo_of(ir); ihi = ir - ilo;
      e1 = g0 + g1; e2 = e1 + g2;
      e.tag = tag;
      e.to = (g0 > lim) || (g1 > lim) || (g2 > lim);
      e.a_on = '0; e.b_rise = '0; e.c_off = '0; e.d_fall = '0; e.e_on = '0; e.f_off = '0;
      if (!e.to) begin
         if (!m) begin e.a_on = CW'(g1); e.b_rise = CW'(g2); e.e_on = (CW+1)'(g1 + g2); end
         else    begin e.c_off = CW'(g1); e.d_fall = CW'(g2); e.f_off = (CW+1)'(g1 + g2); end
      end
      if (push) q.push_back(e);
      do_arm(m, vr, ir, lim);
      n = push ? e2 + 2 : g0 + 1;
      for (int k = 1; k <= n; k++) begin
         if (gappy && (k % 2 == 0)) begin
            smp_valid = 1'b0;                         // R6 garbage on invalid cycle
            vge_smp = m ? '0 : '1; ic_smp = m ? '0 : '1;
            @(negedge clk);
         end
         smp_valid = 1'b1;
         if (!m) begin
            vge_smp = DW'((k >= g0) ? vr : 0);
            if (k < g0)      ic_smp = DW'(spike ? ir : 0);
            else if (k < e1) ic_smp = '0;
            else if (k < e2) ic_smp = DW'(ilo);
            else             ic_smp = DW'(ir);
         end else begin
            vge_smp = DW'((k < g0) ? vr : vhi);
            if (k < g0)      ic_smp = DW'(spike ? 0 : ir);
            else if (k < e1) ic_smp = DW'(ir);
            else if (k < e2) ic_smp = DW'(ihi);
            else             ic_smp = DW'(ilo);
         end
         @(negedge clk);
      end
      smp_valid = 1'b0;
      if (push) begin
         repeat (3) @(negedge clk);
         chk({tag, " R8 queue drained"}, q.size(), 0);
         chk({tag, " R8 pulse over"}, res_valid, 0);
         cmp_all(last);                               // R8 hold until next arm
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset td_on", td_on, 0);
      chk("R9 reset t_off", t_off, 0);
      chk("R9 reset valid", res_valid, 0);
      chk("R9 reset timeout", timed_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      meas("R2 turn-on basic",          0, 4000, 1000, 20,  3, 5, 7,  0, 0, 1);
      meas("R3 turn-off basic",         1, 4000, 1000, 20,  2, 4, 9,  0, 0, 1);
      meas("R1 R2 full-scale refs",     0, 4095, 4095, 20,  1, 1, 1,  0, 0, 1);
      meas("R3 full-scale refs",        1, 4095, 2047, 20,  1, 1, 1,  0, 0, 1);
      meas("R6 gappy turn-on",          0, 3000, 800,  20,  4, 6, 3,  1, 0, 1);
      meas("R6 gappy turn-off",         1, 3000, 800,  20,  2, 3, 5,  1, 0, 1);
      meas("R5 order turn-on spike",    0, 4000, 1000, 20,  5, 2, 2,  0, 1, 1);
      meas("R5 order turn-off spike",   1, 4000, 1000, 20,  6, 3, 4,  0, 1, 1);
      meas("R7 limit equal accepted",   0, 4000, 1000, 20, 20, 20, 20, 0, 0, 1);
      meas("R7 timeout first gap",      0, 4000, 1000, 20,  3, 21, 2, 0, 0, 1);
      meas("R7 timeout gate",           1, 4000, 1000, 20, 21, 2, 2,  0, 0, 1);
      meas("R7 timeout second gap",     1, 4000, 1000, 20,  2, 3, 21, 0, 0, 1);
      meas("R10 abandoned",             0, 4000, 1000, 20,  3, 5, 5,  0, 0, 0);
      meas("R10 restart",               1, 2000, 600,  20,  2, 2, 6,  0, 0, 1);
      meas("R4 R8 after timeout clear", 0, 2000, 600,  15,  2, 8, 9,  0, 0, 1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule